// File: doc/BRIEF.md
# Doorbell Mailbox Register Unit

This block is a memory-mapped mailbox that lets one processor signal another. It holds three channels, each with a 32-bit pending word. A sender raises bits by writing ones to a set register, and the receiver acknowledges them by writing ones to a clear register. Zero bits in either write have no effect. Because of this, many software users can share one channel, each owning its own bits, and no read-modify-write sequence or lock is needed.

A channel can be used in two ways. In doorbell use, every bit is its own signal. In single-word use, the sender writes one non-zero 32-bit value and the receiver clears it once it has been consumed. Each channel drives a level interrupt toward the receiver, and that interrupt stays high while the channel's word is non-zero. Channel 0 is reserved for secure masters: a request that carries the non-secure attribute cannot see or change it, and the unit flags such a request with an error.

The bus side is a simple single-cycle request port. Writes take effect at the clock edge that samples the request. Read data and the error flag are registered, so they are valid in the cycle after the request. In every other cycle both are zero.

Top module: `dbell_mbox_regs`

## Requirements
- R1: While reset is held and right after it, every pending word is zero, all three interrupts are low, and `bus_rdata` and `bus_err` are zero.
- R2: A permitted write to a channel's set register (offset 0x08 within the channel) ORs `bus_wdata` into that channel's pending word. Bits written as zero keep their value.
- R3: A permitted write to a channel's clear register (offset 0x10) clears each pending bit whose `bus_wdata` bit is one. Bits written as zero keep their value.
- R4: A permitted read of a channel's status register (offset 0x00) returns its pending word on `bus_rdata` in the cycle after the request. When there is no request, `bus_rdata` and `bus_err` are zero in the following cycle.
- R5: Reading a set or clear register returns zero. A write to a status register changes nothing.
- R6: `irq[n]` is high exactly while channel n's pending word is non-zero. This covers both a single non-zero word and any group of doorbell bits.
- R7: Channel 0 is secure. A request with `bus_nonsec`=1 to any channel-0 register changes nothing, reads as zero, and raises `bus_err` in the cycle after the request. Secure requests (`bus_nonsec`=0) may reach every channel.
- R8: A write to one channel leaves the pending words of the other channels unchanged.
- R9: Channel n occupies addresses n*0x20 to n*0x20+0x1F, with n taken from `bus_addr[7:5]`. An address whose channel index is 3 or more, or whose offset is not 0x00, 0x08 or 0x10, reads as zero, changes nothing and does not raise `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Request strobe, one access per asserted cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_nonsec | input | 1 | 1 = non-secure request |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data, used as a set or clear mask |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| bus_err | output | 1 | Security violation flag, valid the cycle after the request |
| irq | output | 3 | Per-channel level interrupt, bit n for channel n |

## Verification
The assertions assume that `bus_req`, `bus_wr` and `bus_nonsec` are known whenever reset is released, and that they are held low while reset is applied. Only then is the `$past` data on a write the mask that was actually applied. The stimulus changes inputs only on the falling clock edge and issues each access as a single-cycle strobe. It always returns `bus_req` to low during reset, so every antecedent starts from a defined bus state.

// File: rtl/dbell_mbox_pkg.sv
`timescale 1ns/1ps
package dbell_mbox_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_STATUS = 2'd1,
    KIND_SET    = 2'd2,
    KIND_CLEAR  = 2'd3
  } reg_kind_e;

  // Clear mask first, then the set mask, so a set bit wins over a clear.
  function automatic logic [DATA_W-1:0] merge_masks(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] set_m,
    input logic [DATA_W-1:0] clr_m);
    return (cur & ~clr_m) | set_m;
  endfunction

  function automatic logic word_pending(input logic [DATA_W-1:0] w);
    return |w;
  endfunction
endpackage

// File: rtl/dbell_addr_decode.sv
`timescale 1ns/1ps
module dbell_addr_decode
  import dbell_mbox_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_CHAN   = 3,
  parameter int SPAN_LOG2  = 5,
  parameter int SEC_CHAN   = 0,
  parameter int OFF_STATUS = 0,
  parameter int OFF_SET    = 8,
  parameter int OFF_CLEAR  = 16,
  localparam int CH_W      = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic                req,
  input  logic                wr,
  input  logic                nonsec,
  input  logic [ADDR_W-1:0]   addr,
  output logic [CH_W-1:0]     chan_idx,
  output logic                sec_block,
  output logic                rd_status,
  output logic [NUM_CHAN-1:0] set_hit,
  output logic [NUM_CHAN-1:0] clr_hit
);
  localparam int CF_W = ADDR_W - SPAN_LOG2;

  logic [CF_W-1:0]      chan_field;
  logic [SPAN_LOG2-1:0] off_field;
  logic                 mapped;
  logic                 access_ok;
  reg_kind_e            kind;

  assign chan_field = addr[ADDR_W-1:SPAN_LOG2];
  assign off_field  = addr[SPAN_LOG2-1:0];
  assign mapped     = chan_field < CF_W'(NUM_CHAN);
  assign chan_idx   = chan_field[CH_W-1:0];

  always_comb begin
    if (off_field == SPAN_LOG2'(OFF_STATUS))     kind = KIND_STATUS;
    else if (off_field == SPAN_LOG2'(OFF_SET))   kind = KIND_SET;
    else if (off_field == SPAN_LOG2'(OFF_CLEAR)) kind = KIND_CLEAR;
    else                                         kind = KIND_NONE;
  end

  assign sec_block = req && nonsec && (chan_field == CF_W'(SEC_CHAN));
  assign access_ok = req && mapped && !sec_block;
  assign rd_status = access_ok && !wr && (kind == KIND_STATUS);

  for (genvar gi = 0; gi < NUM_CHAN; gi++) begin : g_hit
    assign set_hit[gi] = access_ok && wr && (kind == KIND_SET)
                         && (chan_field == CF_W'(gi));
    assign clr_hit[gi] = access_ok && wr && (kind == KIND_CLEAR)
                         && (chan_field == CF_W'(gi));
  end
endmodule

// File: rtl/dbell_chan.sv
`timescale 1ns/1ps
module dbell_chan
  import dbell_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] status,
  output logic              irq
);
  logic [DATA_W-1:0] set_mask;
  logic [DATA_W-1:0] clr_mask;

  assign set_mask = set_en ? wdata : '0;
  assign clr_mask = clr_en ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= merge_masks(status, set_mask, clr_mask);
  end

  assign irq = word_pending(status);
endmodule

// File: rtl/dbell_mbox_regs.sv
`timescale 1ns/1ps
module dbell_mbox_regs
  import dbell_mbox_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_CHAN  = 3,
  parameter int SPAN_LOG2 = 5,
  parameter int SEC_CHAN  = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req,
  input  logic                bus_wr,
  input  logic                bus_nonsec,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_err,
  output logic [NUM_CHAN-1:0] irq
);
  localparam int CH_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;

  logic [CH_W-1:0]            chan_idx;
  logic                       sec_block;
  logic                       rd_status;
  logic [NUM_CHAN-1:0]        set_hit;
  logic [NUM_CHAN-1:0]        clr_hit;
  logic [DATA_W-1:0]          status_arr [NUM_CHAN];
  logic [NUM_CHAN*DATA_W-1:0] status_flat;
  logic [DATA_W-1:0]          rdata_d;

  dbell_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_CHAN(NUM_CHAN),
    .SPAN_LOG2(SPAN_LOG2), .SEC_CHAN(SEC_CHAN)
  ) dec_i (
    .req(bus_req), .wr(bus_wr), .nonsec(bus_nonsec), .addr(bus_addr),
    .chan_idx(chan_idx), .sec_block(sec_block), .rd_status(rd_status),
    .set_hit(set_hit), .clr_hit(clr_hit)
  );

  for (genvar gc = 0; gc < NUM_CHAN; gc++) begin : g_chan
    dbell_chan chan_i (
      .clk(clk), .rst_n(rst_n),
      .set_en(set_hit[gc]), .clr_en(clr_hit[gc]),
      .wdata(bus_wdata),
      .status(status_arr[gc]), .irq(irq[gc])
    );
    assign status_flat[gc*DATA_W +: DATA_W] = status_arr[gc];
  end

  assign rdata_d = rd_status ? status_arr[chan_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rdata_d;
      bus_err   <= sec_block;
    end
  end
endmodule

// File: rtl/dbell_mbox_chk.sv
`timescale 1ns/1ps
module dbell_mbox_chk
  import dbell_mbox_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_CHAN  = 3,
  parameter int SPAN_LOG2 = 5,
  parameter int SEC_CHAN  = 0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_req,
  input logic                       bus_nonsec,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic                       bus_err,
  input logic [NUM_CHAN-1:0]        irq,
  input logic [NUM_CHAN*DATA_W-1:0] status_flat,
  input logic [NUM_CHAN-1:0]        set_hit,
  input logic [NUM_CHAN-1:0]        clr_hit
);
  logic sec_touch;
  assign sec_touch = bus_req && bus_nonsec
                     && (bus_addr[ADDR_W-1:SPAN_LOG2] == (ADDR_W-SPAN_LOG2)'(SEC_CHAN));

  AST_SEC_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    sec_touch |=> (bus_err && bus_rdata == '0)); // R7
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sec_touch |=> $stable(status_flat[SEC_CHAN*DATA_W +: DATA_W])); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> (bus_rdata == '0 && !bus_err)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> $stable(status_flat)); // R8

  for (genvar gk = 0; gk < NUM_CHAN; gk++) begin : g_chk
    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      set_hit[gk] |=> ((status_flat[gk*DATA_W +: DATA_W] & $past(bus_wdata))
                       == $past(bus_wdata))); // R2
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit[gk] |=> ((status_flat[gk*DATA_W +: DATA_W] & $past(bus_wdata))
                       == '0)); // R3
    AST_IRQ_AFTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (set_hit[gk] && bus_wdata != '0) |=> irq[gk]); // R6
  end
endmodule

bind dbell_mbox_regs dbell_mbox_chk #(
  .ADDR_W(ADDR_W), .NUM_CHAN(NUM_CHAN),
  .SPAN_LOG2(SPAN_LOG2), .SEC_CHAN(SEC_CHAN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_nonsec(bus_nonsec),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_err(bus_err), .irq(irq), .status_flat(status_flat),
  .set_hit(set_hit), .clr_hit(clr_hit)
);

// File: tb/dbell_mbox_regs_tb_top.sv
`timescale 1ns/1ps
module dbell_mbox_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_nonsec = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [2:0]  irq;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] model_word [3];

  always #2.5 clk = ~clk;

  dbell_mbox_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_nonsec(bus_nonsec), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq)
  );

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at the falling edge, advance the model, compare after the edge.
  task automatic cyc(input bit rq, input bit wr, input bit ns,
                     input logic [7:0] a, input logic [31:0] d, input string tag);
    int ch = a / 32;
    int off = a % 32;
    logic [31:0] exp_rd = '0;
    bit exp_err = 0;
    logic [2:0] exp_irq;
    bus_req = rq; bus_wr = wr; bus_nonsec = ns; bus_addr = a; bus_wdata = d;
    if (rq) begin
      if (ch == 0 && ns) exp_err = 1;
      else if (ch < 3) begin
        if (!wr && off == 0) exp_rd = model_word[ch];
        if (wr && off == 8)  model_word[ch] = model_word[ch] | d;
        if (wr && off == 16) model_word[ch] = model_word[ch] & ~d;
      end
    end
    for (int i = 0; i < 3; i++) exp_irq[i] = (model_word[i] != 0);
    @(negedge clk);
    check32({tag, " rdata"}, bus_rdata, exp_rd);
    check32({tag, " err"}, {31'd0, bus_err}, {31'd0, exp_err});
    check32({tag, " irq"}, {29'd0, irq}, {29'd0, exp_irq});
  endtask

  task automatic rd(input logic [7:0] a, input bit ns, input string tag);
    cyc(1, 0, ns, a, 32'h0, tag);
  endtask
  task automatic wrt(input logic [7:0] a, input bit ns, input logic [31:0] d, input string tag);
    cyc(1, 1, ns, a, d, tag);
  endtask
  task automatic idle(input string tag);
    cyc(0, 0, 0, 8'h00, 32'h0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) model_word[i] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is held
    check32("R1 rdata in reset", bus_rdata, 32'h0);
    check32("R1 err in reset", {31'd0, bus_err}, 32'h0);
    check32("R1 irq in reset", {29'd0, irq}, 32'h0);
    rst_n = 1'b1;
    idle("R1 after reset");
    for (int c = 0; c < 3; c++) rd(8'(c * 32), 0, "R1 status zero");

    // R2 doorbell bits accumulate on channel 1, R6 interrupt rises
    wrt(8'h28, 1, 32'h0000_0005, "R2 set ch1");
    rd(8'h20, 1, "R2 read ch1");
    wrt(8'h28, 1, 32'h0000_0100, "R2 set more ch1");
    rd(8'h20, 1, "R2 read ch1 accum");
    idle("R6 irq held");

    // R3 selective clear, then full clear drops the interrupt (R6)
    wrt(8'h30, 1, 32'h0000_0004, "R3 clear one bit");
    rd(8'h20, 1, "R3 read after clear");
    wrt(8'h30, 1, 32'h0000_0101, "R3 clear rest");
    idle("R6 irq low");
    rd(8'h20, 1, "R3 read zero");

    // Single-word use on channel 2
    wrt(8'h48, 1, 32'hDEAD_BEEF, "R6 word ch2");
    rd(8'h40, 1, "R4 read word ch2");
    // R5 write to status ignored, set/clear read as zero
    wrt(8'h40, 1, 32'h0000_FFFF, "R5 write status");
    rd(8'h40, 1, "R5 status unchanged");
    rd(8'h48, 1, "R5 read set reg");
    rd(8'h50, 1, "R5 read clear reg");
    // R8 channel 1 untouched by channel 2 traffic
    rd(8'h20, 1, "R8 ch1 untouched");
    wrt(8'h28, 0, 32'h8000_0001, "R8 set ch1 secure master");
    rd(8'h40, 0, "R8 ch2 untouched");
    wrt(8'h50, 0, 32'hFFFF_FFFF, "R3 clear word ch2");
    rd(8'h40, 0, "R3 ch2 empty");

    // R7 secure channel
    wrt(8'h08, 1, 32'h0000_00FF, "R7 nonsec set ch0");
    rd(8'h00, 0, "R7 ch0 still zero");
    wrt(8'h08, 0, 32'h0000_00A5, "R7 secure set ch0");
    rd(8'h00, 0, "R7 secure read ch0");
    rd(8'h00, 1, "R7 nonsec read ch0");
    wrt(8'h10, 1, 32'hFFFF_FFFF, "R7 nonsec clear ch0");
    rd(8'h00, 0, "R7 ch0 kept");
    rd(8'h1C, 1, "R7 nonsec odd offset ch0");

    // R9 unmapped space
    wrt(8'h68, 0, 32'hFFFF_FFFF, "R9 write chan3");
    wrt(8'h04, 0, 32'hFFFF_FFFF, "R9 write odd offset");
    wrt(8'h2C, 1, 32'h0000_0F00, "R9 write odd offset ch1");
    rd(8'hE0, 1, "R9 read high index");
    rd(8'h7C, 0, "R9 read unmapped");
    for (int c = 0; c < 3; c++) rd(8'(c * 32), 0, "R9 nothing changed");

    // R8 clear ch0 leaves ch1
    wrt(8'h10, 0, 32'h0000_00A5, "R8 clear ch0");
    rd(8'h20, 0, "R8 ch1 kept");
    repeat (3) idle("R4 idle quiet");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule